// File: doc/BRIEF.md
# Dual-Requester Reconfiguration Bus Arbiter

This block lets two reconfiguration managers share one transceiver reconfiguration port. One manager serves the receive side and the other serves the transmit side. Each manager has a simple memory-mapped port: read and write strobes, a 10-bit address, 32-bit write data, 32-bit read data and a waitrequest. The arbiter forwards one transaction at a time to the single downstream port. It then returns the downstream read data and waitrequest only to the manager that owns the transaction. The downstream side supplies a separate read-data bus and a separate waitrequest for each direction.

The arbiter also records which side issued the last completed write, since that write starts a recalibration. It uses that record to decide which PHY reset controller sees the transceiver's calibration-busy indications. While the recorded owner's calibration is still busy, the other side is kept waiting, so receive and transmit recalibrations never overlap. Per-side enable inputs and a per-side 2-bit channel select qualify each request. The block runs on the managers' clock and reset.

Top module: `xcvr_cfg_arbiter`

## Requirements
- R1: While reset is asserted and directly after it, no side is granted: `rx_wait` and `tx_wait` are 1, `phy_wr` and `phy_rd` are 0, and `phy_addr` and `phy_wdata` are 0.
- R2: A qualified request (strobe `*_wr` or `*_rd` high) from an idle arbiter is granted at the next clock edge. From then on, `phy_wr`, `phy_rd`, `phy_addr` and `phy_wdata` follow that side's inputs combinationally. With no grant they are all 0.
- R3: A grant lasts until the granted side's downstream waitrequest (`phy_rx_wait` for receive, `phy_tx_wait` for transmit) is 0 while its strobe is high. While granted, that side's upstream waitrequest equals its downstream waitrequest.
- R4: The side that is not granted sees its upstream waitrequest at 1. At most one upstream waitrequest is 0 in any cycle.
- R5: When both sides make a qualified request in the same idle cycle, the side not served last wins. After reset, receive counts as the side that has not been served, so it wins the first tie.
- R6: A side whose enable (`rx_en` / `tx_en`) is 0 is never granted, and its waitrequest stays 1.
- R7: A side whose channel select differs from parameter `CHAN_ID` (default 2'b00) is never granted.
- R8: A side's upstream read data equals its own downstream read data (`phy_rx_rdata` / `phy_tx_rdata`) while that side is granted, and is 0 otherwise.
- R9: A completed write sets the calibration owner to the writing side; a completed read leaves it unchanged. With no owner, `cal_rx_out`=`cal_rx_in` and `cal_tx_out`=`cal_tx_in`. With owner receive, `cal_rx_out` = `cal_rx_in|cal_tx_in` and `cal_tx_out`=0. Owner transmit is the mirror case.
- R10: While an owner is recorded and either calibration-busy input is 1, the non-owner side is not granted. The owner side may still be granted.
- R11: When a transaction completes, or the granted side drops its strobe, the grant returns to idle at the next edge. That leaves at least one idle cycle between transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the reconfiguration managers |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive side may request access |
| rx_chan | input | CHAN_W | Receive channel select |
| rx_wr | input | 1 | Receive manager write strobe |
| rx_rd | input | 1 | Receive manager read strobe |
| rx_addr | input | ADDR_W | Receive manager address |
| rx_wdata | input | DATA_W | Receive manager write data |
| rx_rdata | output | DATA_W | Read data returned to receive manager |
| rx_wait | output | 1 | Waitrequest to receive manager |
| tx_en | input | 1 | Transmit side may request access |
| tx_chan | input | CHAN_W | Transmit channel select |
| tx_wr | input | 1 | Transmit manager write strobe |
| tx_rd | input | 1 | Transmit manager read strobe |
| tx_addr | input | ADDR_W | Transmit manager address |
| tx_wdata | input | DATA_W | Transmit manager write data |
| tx_rdata | output | DATA_W | Read data returned to transmit manager |
| tx_wait | output | 1 | Waitrequest to transmit manager |
| phy_wr | output | 1 | Downstream write strobe |
| phy_rd | output | 1 | Downstream read strobe |
| phy_addr | output | ADDR_W | Downstream address |
| phy_wdata | output | DATA_W | Downstream write data |
| phy_rx_rdata | input | DATA_W | Downstream read data for receive transactions |
| phy_rx_wait | input | 1 | Downstream waitrequest for receive transactions |
| phy_tx_rdata | input | DATA_W | Downstream read data for transmit transactions |
| phy_tx_wait | input | 1 | Downstream waitrequest for transmit transactions |
| cal_rx_in | input | 1 | Transceiver receive calibration busy |
| cal_tx_in | input | 1 | Transceiver transmit calibration busy |
| cal_rx_out | output | 1 | Gated calibration busy to receive reset controller |
| cal_tx_out | output | 1 | Gated calibration busy to transmit reset controller |

## Verification
The bench targets several corner cases:

- **Same-cycle tie.** Both sides request in one idle cycle, first right after reset and then after each side has been served. A fixed-priority design would starve transmit, and a design that updated the last-served side at grant time instead of at completion would pick the wrong winner.
- **Held grant.** A grant is kept across several downstream wait cycles, and the downstream read data is changed while the other side is granted. A design that dropped the grant early or returned the wrong side's data would show mismatching addresses or read data.
- **Calibration lock.** A request from the non-owner is held off while the owner's calibration runs. A design that ignored the lock would assert `phy_wr` during calibration. A design that let a read change the owner would gate the busy outputs to the wrong side.
- **Disqualified requests.** Requests with the enable cleared or with a non-matching channel select must never reach the downstream port.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;

  // Encoding of the requesting side; SIDE_NONE means no grant / no owner.
  typedef enum logic [1:0] {
    SIDE_NONE = 2'b00,
    SIDE_RX   = 2'b01,
    SIDE_TX   = 2'b10
  } side_e;

  // Index 0 of every per-side array is receive, index 1 is transmit.
  localparam int NUM_SIDES = 2;

endpackage

// File: rtl/xcfg_req_qual.sv
module xcfg_req_qual #(
  parameter int CHAN_W  = 2,
  parameter int CHAN_ID = 0
) (
  input  logic              en,
  input  logic [CHAN_W-1:0] chan,
  input  logic              wr,
  input  logic              rd,
  input  logic              blocked,
  output logic              req
);

  localparam logic [CHAN_W-1:0] CHAN_SEL = CHAN_W'(CHAN_ID);

  logic chan_hit;
  logic strobe;

  assign chan_hit = (chan == CHAN_SEL);
  assign strobe   = wr | rd;
  assign req      = en & chan_hit & strobe & ~blocked;

endmodule

// File: rtl/xcfg_grant_fsm.sv
module xcfg_grant_fsm
  import xcfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SIDES-1:0] req,
  input  logic [NUM_SIDES-1:0] active,
  input  logic [NUM_SIDES-1:0] dwait,
  output side_e                gnt,
  output side_e                last_side,
  output logic                 done
);

  side_e gnt_q, gnt_d;
  side_e last_q, last_d;
  logic  upd;

  // Next-state: pick a side from idle, hold until downstream accepts.
  always_comb begin
    gnt_d  = gnt_q;
    last_d = last_q;
    done   = 1'b0;
    unique case (gnt_q)
      SIDE_NONE: begin
        if (req[0] && req[1]) begin
          gnt_d = (last_q == SIDE_RX) ? SIDE_TX : SIDE_RX;
        end else if (req[0]) begin
          gnt_d = SIDE_RX;
        end else if (req[1]) begin
          gnt_d = SIDE_TX;
        end
      end
      SIDE_RX: begin
        if (!active[0]) begin
          gnt_d = SIDE_NONE;
        end else if (!dwait[0]) begin
          gnt_d  = SIDE_NONE;
          last_d = SIDE_RX;
          done   = 1'b1;
        end
      end
      SIDE_TX: begin
        if (!active[1]) begin
          gnt_d = SIDE_NONE;
        end else if (!dwait[1]) begin
          gnt_d  = SIDE_NONE;
          last_d = SIDE_TX;
          done   = 1'b1;
        end
      end
      default: gnt_d = SIDE_NONE;
    endcase
  end

  assign upd = (gnt_d != gnt_q) || (last_d != last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= SIDE_NONE;
      last_q <= SIDE_TX;
    end else if (upd) begin
      gnt_q  <= gnt_d;
      last_q <= last_d;
    end
  end

  assign gnt       = gnt_q;
  assign last_side = last_q;

endmodule

// File: rtl/xcfg_cal_owner.sv
module xcfg_cal_owner
  import xcfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic                 done_is_wr,
  input  side_e                done_side,
  input  logic [NUM_SIDES-1:0] cal_in,
  output side_e                owner,
  output logic [NUM_SIDES-1:0] blocked,
  output logic [NUM_SIDES-1:0] cal_out
);

  side_e owner_q, owner_d;
  logic  own_en;
  logic  cal_any;

  assign cal_any = |cal_in;
  assign own_en  = done & done_is_wr;

  always_comb begin
    owner_d = owner_q;
    if (own_en) owner_d = done_side;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= SIDE_NONE;
    end else if (own_en) begin
      owner_q <= owner_d;
    end
  end

  // Calibration of the owner keeps the other side off the port.
  assign blocked[0] = (owner_q == SIDE_TX) & cal_any;
  assign blocked[1] = (owner_q == SIDE_RX) & cal_any;

  always_comb begin
    unique case (owner_q)
      SIDE_RX: cal_out = {1'b0, cal_any};
      SIDE_TX: cal_out = {cal_any, 1'b0};
      default: cal_out = cal_in;
    endcase
  end

  assign owner = owner_q;

endmodule

// File: rtl/xcfg_bus_mux.sv
module xcfg_bus_mux
  import xcfg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  side_e                gnt,
  input  logic [NUM_SIDES-1:0] up_wr,
  input  logic [NUM_SIDES-1:0] up_rd,
  input  logic [ADDR_W-1:0]    up_addr  [NUM_SIDES],
  input  logic [DATA_W-1:0]    up_wdata [NUM_SIDES],
  input  logic [NUM_SIDES-1:0] dwait,
  input  logic [DATA_W-1:0]    drdata   [NUM_SIDES],
  output logic                 phy_wr,
  output logic                 phy_rd,
  output logic [ADDR_W-1:0]    phy_addr,
  output logic [DATA_W-1:0]    phy_wdata,
  output logic [NUM_SIDES-1:0] up_wait,
  output logic [DATA_W-1:0]    up_rdata [NUM_SIDES]
);

  // Forward path: only the granted side reaches the downstream port.
  always_comb begin
    phy_wr    = 1'b0;
    phy_rd    = 1'b0;
    phy_addr  = '0;
    phy_wdata = '0;
    unique case (gnt)
      SIDE_RX: begin
        phy_wr    = up_wr[0];
        phy_rd    = up_rd[0];
        phy_addr  = up_addr[0];
        phy_wdata = up_wdata[0];
      end
      SIDE_TX: begin
        phy_wr    = up_wr[1];
        phy_rd    = up_rd[1];
        phy_addr  = up_addr[1];
        phy_wdata = up_wdata[1];
      end
      default: ;
    endcase
  end

  // Return path: each side gets its own downstream signals when granted.
  for (genvar i = 0; i < NUM_SIDES; i++) begin : g_ret
    localparam side_e SIDE = (i == 0) ? SIDE_RX : SIDE_TX;
    logic own;
    assign own         = (gnt == SIDE);
    assign up_wait[i]  = own ? dwait[i] : 1'b1;
    assign up_rdata[i] = own ? drdata[i] : '0;
  end

endmodule

// File: rtl/xcvr_cfg_arbiter.sv
module xcvr_cfg_arbiter
  import xcfg_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int CHAN_W  = 2,
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [CHAN_W-1:0] rx_chan,
  input  logic              rx_wr,
  input  logic              rx_rd,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [DATA_W-1:0] rx_wdata,
  output logic [DATA_W-1:0] rx_rdata,
  output logic              rx_wait,
  input  logic              tx_en,
  input  logic [CHAN_W-1:0] tx_chan,
  input  logic              tx_wr,
  input  logic              tx_rd,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic [DATA_W-1:0] tx_rdata,
  output logic              tx_wait,
  output logic              phy_wr,
  output logic              phy_rd,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  input  logic [DATA_W-1:0] phy_rx_rdata,
  input  logic              phy_rx_wait,
  input  logic [DATA_W-1:0] phy_tx_rdata,
  input  logic              phy_tx_wait,
  input  logic              cal_rx_in,
  input  logic              cal_tx_in,
  output logic              cal_rx_out,
  output logic              cal_tx_out
);

  localparam int NS = NUM_SIDES;

  logic [NS-1:0]     s_en, s_wr, s_rd, s_active, s_req, s_blocked;
  logic [CHAN_W-1:0] s_chan   [NS];
  logic [ADDR_W-1:0] s_addr   [NS];
  logic [DATA_W-1:0] s_wdata  [NS];
  logic [DATA_W-1:0] s_drdata [NS];
  logic [DATA_W-1:0] s_urdata [NS];
  logic [NS-1:0]     s_dwait, s_uwait, s_cal_in, s_cal_out;

  side_e gnt, last_side, owner;
  logic  done;

  // Pack the two sides into per-side arrays (0 = receive, 1 = transmit).
  assign s_en     = {tx_en, rx_en};
  assign s_wr     = {tx_wr, rx_wr};
  assign s_rd     = {tx_rd, rx_rd};
  assign s_dwait  = {phy_tx_wait, phy_rx_wait};
  assign s_cal_in = {cal_tx_in, cal_rx_in};
  assign s_chan[0]   = rx_chan;
  assign s_chan[1]   = tx_chan;
  assign s_addr[0]   = rx_addr;
  assign s_addr[1]   = tx_addr;
  assign s_wdata[0]  = rx_wdata;
  assign s_wdata[1]  = tx_wdata;
  assign s_drdata[0] = phy_rx_rdata;
  assign s_drdata[1] = phy_tx_rdata;
  assign s_active    = s_wr | s_rd;

  for (genvar i = 0; i < NS; i++) begin : g_side
    xcfg_req_qual #(
      .CHAN_W (CHAN_W),
      .CHAN_ID(CHAN_ID)
    ) i_qual (
      .en     (s_en[i]),
      .chan   (s_chan[i]),
      .wr     (s_wr[i]),
      .rd     (s_rd[i]),
      .blocked(s_blocked[i]),
      .req    (s_req[i])
    );
  end

  xcfg_grant_fsm i_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (s_req),
    .active   (s_active),
    .dwait    (s_dwait),
    .gnt      (gnt),
    .last_side(last_side),
    .done     (done)
  );

  xcfg_cal_owner i_owner (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .done_is_wr(phy_wr),
    .done_side (gnt),
    .cal_in    (s_cal_in),
    .owner     (owner),
    .blocked   (s_blocked),
    .cal_out   (s_cal_out)
  );

  xcfg_bus_mux #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_mux (
    .gnt      (gnt),
    .up_wr    (s_wr),
    .up_rd    (s_rd),
    .up_addr  (s_addr),
    .up_wdata (s_wdata),
    .dwait    (s_dwait),
    .drdata   (s_drdata),
    .phy_wr   (phy_wr),
    .phy_rd   (phy_rd),
    .phy_addr (phy_addr),
    .phy_wdata(phy_wdata),
    .up_wait  (s_uwait),
    .up_rdata (s_urdata)
  );

  assign rx_wait    = s_uwait[0];
  assign tx_wait    = s_uwait[1];
  assign rx_rdata   = s_urdata[0];
  assign tx_rdata   = s_urdata[1];
  assign cal_rx_out = s_cal_out[0];
  assign cal_tx_out = s_cal_out[1];

endmodule

// File: rtl/xcfg_arbiter_checker.sv
module xcfg_arbiter_checker
  import xcfg_pkg::*;
#(
  parameter int CHAN_W  = 2,
  parameter int CHAN_ID = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic [CHAN_W-1:0] rx_chan,
  input logic              rx_wr,
  input logic              rx_rd,
  input logic              rx_wait,
  input logic              tx_en,
  input logic [CHAN_W-1:0] tx_chan,
  input logic              tx_wr,
  input logic              tx_rd,
  input logic              tx_wait,
  input logic              phy_wr,
  input logic              phy_rd,
  input logic              phy_rx_wait,
  input logic              phy_tx_wait,
  input logic              cal_rx_in,
  input logic              cal_tx_in,
  input logic              cal_rx_out,
  input logic              cal_tx_out,
  input side_e             gnt,
  input side_e             last_side,
  input side_e             owner
);

  localparam logic [CHAN_W-1:0] SEL = CHAN_W'(CHAN_ID);

  logic rx_ok, tx_ok, cal_any;
  assign cal_any = cal_rx_in | cal_tx_in;
  assign rx_ok   = rx_en && (rx_chan == SEL) && (rx_wr || rx_rd);
  assign tx_ok   = tx_en && (tx_chan == SEL) && (tx_wr || tx_rd);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (rx_wait && tx_wait && !phy_wr && !phy_rd);
    end
  end

  assert_one_wait_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rx_wait && !tx_wait));

  assert_hold_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == SIDE_RX && (rx_wr || rx_rd) && phy_rx_wait) |=> (gnt == SIDE_RX));

  assert_hold_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == SIDE_TX && (tx_wr || tx_rd) && phy_tx_wait) |=> (gnt == SIDE_TX));

  assert_release_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == SIDE_RX && (rx_wr || rx_rd) && !phy_rx_wait) |=> (gnt == SIDE_NONE));

  assert_release_tx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == SIDE_TX && (tx_wr || tx_rd) && !phy_tx_wait) |=> (gnt == SIDE_NONE));

  assert_rotate_to_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == SIDE_NONE && rx_ok && tx_ok && !cal_any && last_side == SIDE_RX)
    |=> (gnt == SIDE_TX));

  assert_rotate_to_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == SIDE_NONE && rx_ok && tx_ok && !cal_any && last_side == SIDE_TX)
    |=> (gnt == SIDE_RX));

  assert_rx_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == SIDE_NONE && !rx_en) |=> (gnt != SIDE_RX));

  assert_tx_chan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == SIDE_NONE && tx_chan != SEL) |=> (gnt != SIDE_TX));

  assert_mask_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == SIDE_RX) |-> !cal_tx_out);

  assert_mask_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == SIDE_TX) |-> !cal_rx_out);

  assert_lock_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == SIDE_NONE && owner == SIDE_TX && cal_any) |=> (gnt != SIDE_RX));

  assert_lock_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == SIDE_NONE && owner == SIDE_RX && cal_any) |=> (gnt != SIDE_TX));

endmodule

bind xcvr_cfg_arbiter xcfg_arbiter_checker #(
  .CHAN_W (CHAN_W),
  .CHAN_ID(CHAN_ID)
) i_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .rx_chan    (rx_chan),
  .rx_wr      (rx_wr),
  .rx_rd      (rx_rd),
  .rx_wait    (rx_wait),
  .tx_en      (tx_en),
  .tx_chan    (tx_chan),
  .tx_wr      (tx_wr),
  .tx_rd      (tx_rd),
  .tx_wait    (tx_wait),
  .phy_wr     (phy_wr),
  .phy_rd     (phy_rd),
  .phy_rx_wait(phy_rx_wait),
  .phy_tx_wait(phy_tx_wait),
  .cal_rx_in  (cal_rx_in),
  .cal_tx_in  (cal_tx_in),
  .cal_rx_out (cal_rx_out),
  .cal_tx_out (cal_tx_out),
  .gnt        (gnt),
  .last_side  (last_side),
  .owner      (owner)
);

// File: tb/test_xcvr_cfg_arbiter.sv
`timescale 1ns/1ps
module test_xcvr_cfg_arbiter;

  localparam int AW = 10;
  localparam int DW = 32;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_en, tx_en, rx_wr, rx_rd, tx_wr, tx_rd;
  logic [CW-1:0] rx_chan, tx_chan;
  logic [AW-1:0] rx_addr, tx_addr;
  logic [DW-1:0] rx_wdata, tx_wdata;
  logic [DW-1:0] rx_rdata, tx_rdata;
  logic          rx_wait, tx_wait;
  logic          phy_wr, phy_rd;
  logic [AW-1:0] phy_addr;
  logic [DW-1:0] phy_wdata;
  logic [DW-1:0] phy_rx_rdata, phy_tx_rdata;
  logic          phy_rx_wait, phy_tx_wait;
  logic          cal_rx_in, cal_tx_in, cal_rx_out, cal_tx_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  xcvr_cfg_arbiter i_xcvr_cfg_arbiter (
    .clk(clk), .rst_n(rst_n),
    .rx_en(rx_en), .rx_chan(rx_chan), .rx_wr(rx_wr), .rx_rd(rx_rd),
    .rx_addr(rx_addr), .rx_wdata(rx_wdata), .rx_rdata(rx_rdata), .rx_wait(rx_wait),
    .tx_en(tx_en), .tx_chan(tx_chan), .tx_wr(tx_wr), .tx_rd(tx_rd),
    .tx_addr(tx_addr), .tx_wdata(tx_wdata), .tx_rdata(tx_rdata), .tx_wait(tx_wait),
    .phy_wr(phy_wr), .phy_rd(phy_rd), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_rx_rdata(phy_rx_rdata), .phy_rx_wait(phy_rx_wait),
    .phy_tx_rdata(phy_tx_rdata), .phy_tx_wait(phy_tx_wait),
    .cal_rx_in(cal_rx_in), .cal_tx_in(cal_tx_in),
    .cal_rx_out(cal_rx_out), .cal_tx_out(cal_tx_out)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Cycle-by-cycle reference model; 0 none, 1 receive, 2 transmit.
  int m_gnt, m_last, m_own;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_gnt = 0; m_last = 2; m_own = 0;
      cmp("R1", "rx_wait", 64'(rx_wait), 64'd1);
      cmp("R1", "tx_wait", 64'(tx_wait), 64'd1);
      cmp("R1", "phy_wr|rd", 64'({phy_wr, phy_rd}), 64'd0);
      cmp("R1", "phy_addr", 64'(phy_addr), 64'd0);
    end else begin
      logic          e_wr, e_rd, e_rxw, e_txw, e_crx, e_ctx, any_cal, lock;
      logic [AW-1:0] e_addr;
      logic [DW-1:0] e_wd, e_rrx, e_rtx;
      bit            q_rx, q_tx;
      e_wr = 0; e_rd = 0; e_addr = '0; e_wd = '0;
      if (m_gnt == 1) begin e_wr = rx_wr; e_rd = rx_rd; e_addr = rx_addr; e_wd = rx_wdata; end
      if (m_gnt == 2) begin e_wr = tx_wr; e_rd = tx_rd; e_addr = tx_addr; e_wd = tx_wdata; end
      e_rxw = (m_gnt == 1) ? phy_rx_wait : 1'b1;
      e_txw = (m_gnt == 2) ? phy_tx_wait : 1'b1;
      e_rrx = (m_gnt == 1) ? phy_rx_rdata : '0;
      e_rtx = (m_gnt == 2) ? phy_tx_rdata : '0;
      any_cal = cal_rx_in | cal_tx_in;
      e_crx = (m_own == 0) ? cal_rx_in : (m_own == 1) ? any_cal : 1'b0;
      e_ctx = (m_own == 0) ? cal_tx_in : (m_own == 2) ? any_cal : 1'b0;
      cmp("R2", "phy_wr", 64'(phy_wr), 64'(e_wr));
      cmp("R2", "phy_rd", 64'(phy_rd), 64'(e_rd));
      cmp("R2", "phy_addr", 64'(phy_addr), 64'(e_addr));
      cmp("R2", "phy_wdata", 64'(phy_wdata), 64'(e_wd));
      cmp("R3", "rx_wait", 64'(rx_wait), 64'(e_rxw));
      cmp("R4", "tx_wait", 64'(tx_wait), 64'(e_txw));
      cmp("R8", "rx_rdata", 64'(rx_rdata), 64'(e_rrx));
      cmp("R8", "tx_rdata", 64'(tx_rdata), 64'(e_rtx));
      cmp("R9", "cal_rx_out", 64'(cal_rx_out), 64'(e_crx));
      cmp("R9", "cal_tx_out", 64'(cal_tx_out), 64'(e_ctx));
      // next state
      lock = (m_own != 0) && any_cal;
      q_rx = rx_en && rx_chan == 2'b00 && (rx_wr || rx_rd) && !(lock && m_own == 2);
      q_tx = tx_en && tx_chan == 2'b00 && (tx_wr || tx_rd) && !(lock && m_own == 1);
      if (m_gnt == 0) begin
        if (q_rx && q_tx) m_gnt = (m_last == 1) ? 2 : 1;
        else if (q_rx) m_gnt = 1;
        else if (q_tx) m_gnt = 2;
      end else if (m_gnt == 1) begin
        if (!(rx_wr || rx_rd)) m_gnt = 0;
        else if (!phy_rx_wait) begin
          if (rx_wr) m_own = 1;
          m_last = 1; m_gnt = 0;
        end
      end else begin
        if (!(tx_wr || tx_rd)) m_gnt = 0;
        else if (!phy_tx_wait) begin
          if (tx_wr) m_own = 2;
          m_last = 2; m_gnt = 0;
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    rst_n = 0;
    rx_en = 0; tx_en = 0; rx_wr = 0; rx_rd = 0; tx_wr = 0; tx_rd = 0;
    rx_chan = '0; tx_chan = '0; rx_addr = '0; tx_addr = '0;
    rx_wdata = '0; tx_wdata = '0; phy_rx_rdata = '0; phy_tx_rdata = '0;
    phy_rx_wait = 1; phy_tx_wait = 1; cal_rx_in = 0; cal_tx_in = 1;
    repeat (3) tick();
    @(negedge clk);
    cmp("R1", "reset waits", 64'({rx_wait, tx_wait}), 64'h3);
    cmp("R9", "no-owner passthrough", 64'({cal_rx_out, cal_tx_out}), 64'h1);
    tick();
    rst_n = 1; cal_tx_in = 0;
    tick();
    // R5: tie after reset goes to receive.
    rx_en = 1; tx_en = 1;
    rx_wr = 1; rx_addr = 10'h011; rx_wdata = 32'hA5A5_0011;
    tx_rd = 1; tx_addr = 10'h022;
    @(negedge clk);
    cmp("R4", "idle waits", 64'({rx_wait, tx_wait}), 64'h3);
    tick();
    @(negedge clk);
    cmp("R5", "first tie to rx", 64'({phy_wr, phy_addr}), 64'({1'b1, 10'h011}));
    cmp("R2", "wdata forward", 64'(phy_wdata), 64'h0A5A5_0011);
    cmp("R4", "loser waits", 64'(tx_wait), 64'd1);
    tick();
    @(negedge clk);
    cmp("R3", "grant held", 64'({phy_wr, rx_wait}), 64'h3);
    tick();
    phy_rx_wait = 0;
    @(negedge clk);
    cmp("R3", "wait mirrors", 64'(rx_wait), 64'd0);
    tick();
    rx_wr = 0; phy_rx_wait = 1;
    @(negedge clk);
    cmp("R11", "idle gap", 64'({phy_wr, phy_rd}), 64'd0);
    tick();
    phy_tx_wait = 0; phy_tx_rdata = 32'hCAFE_0022; phy_rx_rdata = 32'h1111_2222;
    @(negedge clk);
    cmp("R5", "rotation to tx", 64'({phy_rd, phy_addr}), 64'({1'b1, 10'h022}));
    cmp("R8", "tx read data", 64'(tx_rdata), 64'hCAFE_0022);
    cmp("R8", "rx data gated", 64'(rx_rdata), 64'd0);
    tick();
    tx_rd = 0; phy_tx_wait = 1;
    tick();
    // R9 and R10: receive owns the calibration after its write.
    cal_rx_in = 1;
    tx_wr = 1; tx_addr = 10'h033; tx_wdata = 32'h0000_0033;
    @(negedge clk);
    cmp("R9", "rx owner gating", 64'({cal_rx_out, cal_tx_out}), 64'h2);
    for (int k = 0; k < 3; k++) begin
      tick();
      @(negedge clk);
      cmp("R10", "tx held off", 64'({tx_wait, phy_wr}), 64'h2);
    end
    tick();
    cal_rx_in = 0;
    tick();
    @(negedge clk);
    cmp("R10", "tx after release", 64'({phy_wr, phy_addr}), 64'({1'b1, 10'h033}));
    tick();
    phy_tx_wait = 0;
    tick();
    tx_wr = 0; phy_tx_wait = 1; cal_tx_in = 1;
    @(negedge clk);
    cmp("R9", "tx owner gating", 64'({cal_rx_out, cal_tx_out}), 64'h1);
    tick();
    cal_tx_in = 0;
    // R6: disabled side.
    rx_en = 0; rx_wr = 1; rx_addr = 10'h044; phy_rx_wait = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      @(negedge clk);
      cmp("R6", "disabled rx", 64'({phy_wr, rx_wait}), 64'h1);
    end
    tick();
    rx_wr = 0; rx_en = 1;
    // R7: wrong channel.
    rx_chan = 2'b01; rx_rd = 1;
    for (int k = 0; k < 3; k++) begin
      tick();
      @(negedge clk);
      cmp("R7", "wrong channel", 64'({phy_rd, rx_wait}), 64'h1);
    end
    tick();
    rx_rd = 0; rx_chan = 2'b00;
    // Mixed traffic checked by the reference model every cycle.
    for (int c = 0; c < 6000; c++) begin
      tick();
      if (!(rx_wr || rx_rd) || $urandom_range(4) == 0) begin
        int r = $urandom_range(3);
        rx_wr = (r == 1); rx_rd = (r == 2);
        rx_addr = AW'($urandom); rx_wdata = $urandom;
      end
      if (!(tx_wr || tx_rd) || $urandom_range(4) == 0) begin
        int r = $urandom_range(3);
        tx_wr = (r == 1); tx_rd = (r == 2);
        tx_addr = AW'($urandom); tx_wdata = $urandom;
      end
      rx_en = ($urandom_range(7) != 0);
      tx_en = ($urandom_range(7) != 0);
      rx_chan = ($urandom_range(9) == 0) ? 2'b10 : 2'b00;
      tx_chan = ($urandom_range(9) == 0) ? 2'b01 : 2'b00;
      phy_rx_wait = $urandom_range(1) == 1;
      phy_tx_wait = $urandom_range(1) == 1;
      phy_rx_rdata = $urandom;
      phy_tx_rdata = $urandom;
      if ($urandom_range(7) == 0) cal_rx_in = ~cal_rx_in;
      if ($urandom_range(7) == 0) cal_tx_in = ~cal_tx_in;
    end
    tick();
    summary();
  end

endmodule